// File: doc/BRIEF.md
# I2C Register-Read Target with Windowed Pointer

This block is the target side of a two-wire serial bus that serves register bytes to a bus controller. It oversamples SCL and SDA on a fast system clock. It recognises start, repeated start and stop conditions and compares the 7-bit device address it receives against a parameter. It then takes one of two paths. A write direction stores the next received byte in an internal register pointer. A read direction shifts bytes out, most significant bit first, starting at the pointer.

The pointer does not count in a straight line. The lowest window holds 00h–03h followed by 10h–18h and then returns to 00h. Two small windows hold 30h–32h and 60h–62h, and each wraps back to its own first address. A controller reads at any address by sending a dummy write that carries the register address, then a repeated start and a read. A read with no preceding write continues from where the last read left off.

Register contents come from outside through a plain combinational read port. `rd_addr` always shows the pointer, and `rd_data` must present that address's byte in the same system clock cycle. The port has no handshake and no back-pressure. The block captures `rd_data` in the cycle it starts a byte, and the register file cannot stall it. SDA is open-drain: the bus is pulled low while `sda_oe` is high.

Top module: `i2c_rd_target`

## Requirements
- R1: During and right after reset, `sda_oe` is low and the pointer (`rd_addr`) is 00h.
- R2: When the 7 address bits received after a start equal `DEV_ADDR`, the block pulls SDA low for the ninth clock (ACK). When they do not match, the block never pulls SDA low until the next start condition.
- R3: If the direction bit (eighth bit, 1 = read, 0 = write) is 0, the next byte is acknowledged and loaded into the pointer.
- R4: Read data leaves MSB first, one bit per SCL period. `sda_oe` changes only while SCL is low.
- R5: In the lowest window the pointer steps 00h→01h→02h→03h→10h→11h→…→18h→00h, advancing once for each byte sent.
- R6: The pointer wraps from 32h to 30h and from 62h to 60h.
- R7: A read with no preceding pointer write starts at the address after the last byte sent. Foreign-address traffic does not disturb the pointer.
- R8: After the controller NACKs a data byte, the block sends nothing more until the next start. A controller ACK makes the block send the next byte.
- R9: A pointer value outside all windows is still acknowledged when written. Reading from it returns 00h, and the pointer moves to 00h.
- R10: A stop condition at any point releases SDA and returns the block to idle. The next transfer then works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low (open-drain) |
| rd_addr | output | 8 | Current register pointer, read-port address |
| rd_data | input | 8 | Register byte at `rd_addr`, same cycle |

## Verification
The assertions check some rules on every cycle: SDA drive never changes while the synchronized SCL is high, and the block stays quiet while idle or ignoring the bus. They also check each pointer advance at the gap, at the three wrap points and from an out-of-window value, along with the reset state. Other properties show only through the bench's bus scenarios. These are address matching and its ACK, byte order on the wire, the data returned from every valid start address and several invalid ones, pointer continuity across separate transfers, the controller NACK ending a read, and recovery after an aborted transfer.

// File: rtl/i2c_rt_pkg.sv
package i2c_rt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_REG, ST_REG_ACK, ST_TX, ST_TX_ACK, ST_SKIP
  } rt_state_e;

  localparam int BYTE_W = 8;

  // window limits; the gap after LO_GAP_END is part of the stepping order
  localparam logic [7:0] LO_FIRST   = 8'h00;
  localparam logic [7:0] LO_GAP_END = 8'h03;
  localparam logic [7:0] LO_RESUME  = 8'h10;
  localparam logic [7:0] LO_LAST    = 8'h18;
  localparam logic [7:0] MID_FIRST  = 8'h30;
  localparam logic [7:0] MID_LAST   = 8'h32;
  localparam logic [7:0] HI_FIRST   = 8'h60;
  localparam logic [7:0] HI_LAST    = 8'h62;

  function automatic logic addr_ok(input logic [7:0] a);
    return (a <= LO_GAP_END) ||
           (a >= LO_RESUME && a <= LO_LAST) ||
           (a >= MID_FIRST && a <= MID_LAST) ||
           (a >= HI_FIRST  && a <= HI_LAST);
  endfunction

  function automatic logic [7:0] next_addr(input logic [7:0] a);
    if (a == LO_GAP_END)   return LO_RESUME;
    else if (a == LO_LAST)  return LO_FIRST;
    else if (a == MID_LAST) return MID_FIRST;
    else if (a == HI_LAST)  return HI_FIRST;
    else if (addr_ok(a))    return a + 8'd1;
    else                    return LO_FIRST;
  endfunction

endpackage

// File: rtl/i2c_rt_sync.sv
module i2c_rt_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_rt_cond.sv
module i2c_rt_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_rt_ptr.sv
module i2c_rt_ptr
  import i2c_rt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [7:0]  load_val,
  input  logic        adv,
  input  logic [7:0]  rd_data,
  output logic [7:0]  ptr,
  output logic [7:0]  tx_byte
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= LO_FIRST;
    else if (load) ptr <= load_val;
    else if (adv)  ptr <= next_addr(ptr);
  end

  // out-of-window addresses read as zero
  assign tx_byte = addr_ok(ptr) ? rd_data : 8'h00;
endmodule

// File: rtl/i2c_rd_target.sv
module i2c_rd_target
  import i2c_rt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h0C,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] rd_addr,
  input  logic [7:0] rd_data
);
  localparam logic [3:0] LAST_RX = 4'(BYTE_W);
  localparam logic [3:0] LAST_TX = 4'(BYTE_W - 1);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;
  rt_state_e  state;
  logic [3:0] bitcnt;
  logic [7:0] rx_sh;
  logic [6:0] tx_rest;
  logic       rw, mack;
  logic       ptr_load, ptr_adv;
  logic [7:0] tx_byte;

  i2c_rt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
  i2c_rt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

  i2c_rt_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  always_comb begin
    ptr_load = (state == ST_REG) && scl_fall && (bitcnt == LAST_RX);
    ptr_adv  = scl_fall && (((state == ST_DEV_ACK) && rw) ||
                            ((state == ST_TX_ACK) && mack));
  end

  i2c_rt_ptr u_ptr (
    .clk(clk), .rst_n(rst_n),
    .load(ptr_load), .load_val(rx_sh), .adv(ptr_adv),
    .rd_data(rd_data), .ptr(rd_addr), .tx_byte(tx_byte));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      rx_sh   <= '0;
      tx_rest <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_det) begin
      state  <= ST_DEV;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_DEV, ST_REG: begin
          if (scl_rise) begin
            rx_sh  <= {rx_sh[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == LAST_RX) begin
            bitcnt <= '0;
            if (state == ST_REG) begin
              state  <= ST_REG_ACK;
              sda_oe <= 1'b1;
            end else if (rx_sh[7:1] == DEV_ADDR) begin
              state  <= ST_DEV_ACK;
              rw     <= rx_sh[0];
              sda_oe <= 1'b1;
            end else begin
              state  <= ST_SKIP;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            if (rw) begin
              tx_rest <= tx_byte[6:0];
              sda_oe  <= ~tx_byte[7];
              state   <= ST_TX;
            end else begin
              sda_oe  <= 1'b0;
              state   <= ST_REG;
            end
          end
        end
        ST_REG_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_SKIP;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == LAST_TX) begin
              bitcnt <= '0;
              sda_oe <= 1'b0;
              state  <= ST_TX_ACK;
            end else begin
              sda_oe  <= ~tx_rest[6];
              tx_rest <= {tx_rest[5:0], 1'b1};
              bitcnt  <= bitcnt + 4'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              tx_rest <= tx_byte[6:0];
              sda_oe  <= ~tx_byte[7];
              state   <= ST_TX;
            end else begin
              state   <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_rd_target_chk.sv
module i2c_rd_target_chk
  import i2c_rt_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic [7:0] rd_addr,
  input logic       ptr_adv,
  input rt_state_e  state
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sda_oe && rd_addr == 8'h00));

  a_r4_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  a_r2_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP || state == ST_IDLE) |-> !sda_oe);

  a_r5_gap_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_adv && rd_addr == 8'h03) |=> rd_addr == 8'h10);

  a_r5_low_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_adv && rd_addr == 8'h18) |=> rd_addr == 8'h00);

  a_r6_mid_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_adv && rd_addr == 8'h32) |=> rd_addr == 8'h30);

  a_r6_hi_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_adv && rd_addr == 8'h62) |=> rd_addr == 8'h60);

  a_r9_outside_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_adv && !addr_ok(rd_addr)) |=> rd_addr == 8'h00);
endmodule

bind i2c_rd_target i2c_rd_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .rd_addr(rd_addr), .ptr_adv(ptr_adv), .state(state));

// File: tb/i2c_rd_target_tb.sv
module i2c_rd_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 4 * CLK_PERIOD;
  localparam logic [6:0] DEV = 7'h0C;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [7:0] rd_addr, rd_data;
  wire sda_bus = sda_m & ~sda_oe;
  int checks = 0, fails = 0;
  logic [7:0] model_ptr = 8'h00;
  int oe_seen = 0, viol = 0;
  bit watch = 1'b0;
  logic oe_q = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // register file model
  assign rd_data = rd_addr ^ 8'h5A;

  i2c_rd_target #(.DEV_ADDR(DEV)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .rd_addr(rd_addr), .rd_data(rd_data));

  always @(posedge clk) begin
    if (watch && sda_oe) oe_seen++;
    if (rst_n && scl && (sda_oe !== oe_q)) viol++;
    oe_q <= sda_oe;
  end

  function automatic bit m_valid(input logic [7:0] a);
    return (a < 8'h04) || (a inside {[8'h10:8'h18], [8'h30:8'h32], [8'h60:8'h62]});
  endfunction

  function automatic logic [7:0] m_next(input logic [7:0] a);
    case (a)
      8'h03: return 8'h10;
      8'h18: return 8'h00;
      8'h32: return 8'h30;
      8'h62: return 8'h60;
      default: return m_valid(a) ? a + 8'd1 : 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] m_data(input logic [7:0] a);
    return m_valid(a) ? (a ^ 8'h5A) : 8'h00;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #QTR; scl = 1'b1; #QTR; sda_m = 1'b0; #QTR; scl = 1'b0; #QTR;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #QTR; scl = 1'b1; #QTR; sda_m = 1'b1; #QTR;
  endtask

  task automatic clk_bit(input bit b, output bit seen);
    sda_m = b; #QTR; scl = 1'b1; #QTR; seen = sda_bus; #QTR; scl = 1'b0; #QTR;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(!give_ack, s);
  endtask

  // read n bytes from the current pointer and compare with the model
  task automatic read_run(input int n, input string req);
    bit ack;
    logic [7:0] got;
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    check(ack, "R2 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, got);
      check(got == m_data(model_ptr), req, got, m_data(model_ptr));
      model_ptr = m_next(model_ptr);
    end
    bus_stop();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] got;
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0, "R1 oe in reset", sda_oe, 0);
    check(rd_addr == 8'h00, "R1 pointer in reset", rd_addr, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rd_addr == 8'h00 && !sda_oe, "R1 after release", rd_addr, 0);

    // current read from reset, MSB-first data (R4, R7)
    read_run(3, "R4 R7 current read data");
    check(rd_addr == model_ptr, "R7 pointer after read", rd_addr, model_ptr);

    // random reads from every valid address and some invalid ones
    for (int a = 0; a < 256; a++) begin
      logic [7:0] sa;
      string tag;
      sa = 8'(a);
      if (!(m_valid(sa) || sa inside {8'h05, 8'h20, 8'h7F, 8'hFF})) continue;
      tag = !m_valid(sa) ? "R9 outside window" :
            (sa >= 8'h30) ? "R6 window wrap" : "R5 low window step";
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      check(ack, "R2 write address ack", ack, 1);
      send_byte(sa, ack);
      check(ack, "R3 register byte ack", ack, 1);
      check(rd_addr == sa, "R3 pointer loaded", rd_addr, sa);
      model_ptr = sa;
      read_run(4, tag);
      read_run(1, "R7 continue after random read");
    end

    // foreign address: no drive, pointer unaffected (R2, R7)
    watch = 1'b1; oe_seen = 0;
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b1}, ack);
    check(!ack, "R2 foreign address not acked", ack, 0);
    recv_byte(1'b1, got);
    check(got == 8'hFF, "R2 foreign bus released", got, 8'hFF);
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h61, ack);
    check(oe_seen == 0, "R2 no drive until start", oe_seen, 0);
    bus_stop();
    watch = 1'b0;
    read_run(2, "R7 pointer kept over foreign traffic");

    // NACK ends the read even if clocks continue (R8)
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    recv_byte(1'b0, got);
    check(got == m_data(model_ptr), "R8 byte before nack", got, m_data(model_ptr));
    model_ptr = m_next(model_ptr);
    watch = 1'b1; oe_seen = 0;
    recv_byte(1'b1, got);
    check(got == 8'hFF && oe_seen == 0, "R8 silent after nack", got, 8'hFF);
    watch = 1'b0;
    bus_stop();
    read_run(1, "R8 pointer advanced once");

    // stop in the middle of an address byte (R10)
    bus_start();
    for (int i = 0; i < 4; i++) clk_bit(1'b0, ack);
    bus_stop();
    repeat (8) @(negedge clk);
    check(sda_oe == 1'b0, "R10 released after stop", sda_oe, 0);
    read_run(2, "R10 recovery after abort");

    check(viol == 0, "R4 drive changes only with scl low", viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule